// File: doc/BRIEF.md
# Auxiliary Clock Divider with Bypassable Divide-by-4

This block divides an auxiliary input clock down to the comparison rate of an auxiliary phase detector. The input clock is represented by a single-cycle strobe, `in_tick`, that is sampled on the system clock. Each strobe is one input period. The path has two stages. The first is a fixed divide-by-4 stage, which can be bypassed. The second is a programmable down-counter loaded from a 9-bit ratio.

The total division is either the ratio or four times the ratio. The `bypass_pre` bit selects which. Whenever `enable` is low, the whole path is held at rest. A new ratio or mode is taken in only at the end of a division period, so no period is ever cut short or stretched.

Top module: `aux_divider`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `div_pulse` is 0.
- R2: While `enable` is 0, `div_pulse` stays 0 whatever the other inputs do.
- R3: With `bypass_pre` = 0, consecutive pulses are 4×`ratio` input strobes apart.
- R4: With `bypass_pre` = 1, consecutive pulses are `ratio` input strobes apart.
- R5: A `ratio` value of 0 to 3 behaves exactly as a ratio of 4.
- R6: `div_pulse` is high for exactly one cycle. It is high in the cycle after the input strobe that completes a period.
- R7: After `enable` rises, the first pulse follows exactly one full period of strobes. Counting starts from the first strobe seen while `enable` is 1.
- R8: A change of `ratio` in the middle of a period leaves the current period's length unchanged. The new value sets the length of the following period.
- R9: A change of `bypass_pre` in the middle of a period leaves the current period unchanged. The new value applies from the next period.
- R10: Cycles without an input strobe do not advance the division. Only strobes are counted.
- R11: The largest ratio, 511, gives periods of 511 strobes (bypassed) or 2044 strobes (prescaled).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Enables the division path; 0 holds it at rest |
| bypass_pre | input | 1 | 1 bypasses the divide-by-4 stage, 0 uses it |
| ratio | input | 9 | Programmable division ratio (valid 4..511) |
| in_tick | input | 1 | One-cycle strobe per auxiliary input period |
| div_pulse | output | 1 | One-cycle pulse per division period (registered) |

## Verification
The assertions check several rules on every cycle:
- a pulse never appears without `enable` and an input strobe in the cycle before;
- pulses are never back to back;
- the prescaler stage is idle whenever it is bypassed;
- the counter holds its value on cycles without a strobe;
- the latched mode stays fixed inside a period;
- the counter reload is never below 4.

Other behaviours show only in the bench's scenarios: the period lengths, the clamping of small ratios, and the deferral of a changed ratio or mode until the next period boundary. The bench measures these against a behavioural model that counts strobes.

// File: rtl/auxdiv_pkg.sv
package auxdiv_pkg;
  localparam int RATIO_W   = 9;
  localparam int MIN_RATIO = 4;
  localparam int PRE_RATIO = 4;

  typedef enum logic {
    PATH_DIV4   = 1'b0,
    PATH_DIRECT = 1'b1
  } path_mode_e;
endpackage

// File: rtl/aux_prescaler.sv
module aux_prescaler
  import auxdiv_pkg::*;
#(
  parameter int PRE_DIV = PRE_RATIO
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       in_tick,
  input  path_mode_e mode,
  output logic       stage_tick
);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);

  logic [PW-1:0] phase_q;
  logic          gated_tick;

  assign gated_tick = enable & in_tick;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      phase_q <= '0;
    end else if (gated_tick && mode == PATH_DIV4) begin
      phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end
  end

  assign stage_tick = gated_tick & ((mode == PATH_DIRECT) | (phase_q == LAST));

  AST_BYPASS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (mode == PATH_DIRECT) |-> (phase_q == '0)); // R4
endmodule

// File: rtl/aux_ratio_counter.sv
module aux_ratio_counter
  import auxdiv_pkg::*;
#(
  parameter int W    = RATIO_W,
  parameter int FLOOR = MIN_RATIO
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enable,
  input  logic         stage_tick,
  input  logic [W-1:0] ratio_in,
  input  path_mode_e   mode_in,
  output path_mode_e   mode_q,
  output logic         term
);
  localparam logic [W-1:0] FLOOR_V = W'(FLOOR);
  localparam logic [W-1:0] ONE_V   = W'(1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] load_v;

  assign load_v = (ratio_in < FLOOR_V) ? FLOOR_V : ratio_in;
  assign term   = enable & stage_tick & (cnt_q == ONE_V);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      cnt_q  <= load_v;
      mode_q <= mode_in;
    end else if (stage_tick) begin
      if (cnt_q == ONE_V) begin
        cnt_q  <= load_v;
        mode_q <= mode_in;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  AST_RELOAD_FLOOR: assert property (@(posedge clk) disable iff (rst)
    term |=> (cnt_q >= FLOOR_V)); // R5
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (enable && !stage_tick) |=> $stable(cnt_q)); // R10
  AST_MODE_IN_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (enable && !term) |=> $stable(mode_q)); // R9
endmodule

// File: rtl/aux_divider.sv
module aux_divider
  import auxdiv_pkg::*;
#(
  parameter int W       = RATIO_W,
  parameter int PRE_DIV = PRE_RATIO,
  parameter int FLOOR   = MIN_RATIO
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enable,
  input  logic         bypass_pre,
  input  logic [W-1:0] ratio,
  input  logic         in_tick,
  output logic         div_pulse
);
  path_mode_e mode_req;
  path_mode_e mode_act;
  logic       stage_tick;
  logic       term;

  assign mode_req = bypass_pre ? PATH_DIRECT : PATH_DIV4;

  aux_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .in_tick    (in_tick),
    .mode       (mode_act),
    .stage_tick (stage_tick)
  );

  aux_ratio_counter #(.W(W), .FLOOR(FLOOR)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .stage_tick (stage_tick),
    .ratio_in   (ratio),
    .mode_in    (mode_req),
    .mode_q     (mode_act),
    .term       (term)
  );

  always_ff @(posedge clk) begin
    if (rst) div_pulse <= 1'b0;
    else     div_pulse <= term;
  end

  AST_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> $past(enable)); // R2
  AST_PULSE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> $past(in_tick)); // R6
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse); // R6
endmodule

// File: tb/aux_divider_test.sv
module aux_divider_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic       bypass_pre = 1'b1;
  logic [8:0] ratio = 9'd8;
  logic       in_tick = 1'b0;
  logic       div_pulse;

  int    checks = 0;
  int    fails = 0;
  int    cyc = 0;
  string tag = "R1";
  bit    started = 1'b0;

  int ticks = 0;
  int target = 8;
  bit exp_pulse = 1'b0;

  always #2 clk = ~clk;

  aux_divider uut (
    .clk(clk), .rst(rst), .enable(enable), .bypass_pre(bypass_pre),
    .ratio(ratio), .in_tick(in_tick), .div_pulse(div_pulse)
  );

  function automatic int period_of(input logic [8:0] r, input logic pa);
    int n;
    n = (r < 4) ? 4 : int'(r);
    return pa ? n : 4 * n;
  endfunction

  // behavioural model: count strobes against the period fixed at its start
  always @(posedge clk) begin
    cyc++;
    started = 1'b1;
    exp_pulse = 1'b0;
    if (rst || !enable) begin
      ticks = 0;
      target = period_of(ratio, bypass_pre);
    end else if (in_tick) begin
      ticks++;
      if (ticks == target) begin
        exp_pulse = 1'b1;
        ticks = 0;
        target = period_of(ratio, bypass_pre);
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (div_pulse !== exp_pulse) begin
        fails++;
        $display("FAIL %s cycle %0d: div_pulse=%0b expected %0b", tag, cyc, div_pulse, exp_pulse);
      end
    end
  end

  always @(negedge clk) begin
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run exceeded cycle limit, got %0d expected <150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // counts negedges until a pulse is seen (in_tick driven by caller's pattern)
  task automatic gap_to_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (div_pulse !== 1'b1 && n < 5000);
  endtask

  task automatic restart(input logic [8:0] r, input logic pa);
    @(negedge clk);
    enable = 1'b0;
    ratio = r;
    bypass_pre = pa;
    in_tick = 1'b1;
    @(negedge clk);
    enable = 1'b1;
  endtask

  initial begin
    int g;
    int cnt;
    // R1: reset
    in_tick = 1'b1;
    repeat (3) @(negedge clk);
    check_int("R1", int'(div_pulse), 0);
    rst = 1'b0;
    @(negedge clk);
    check_int("R1", int'(div_pulse), 0);

    // R2: disabled, strobes present
    tag = "R2";
    cnt = 0;
    repeat (40) begin
      @(negedge clk);
      if (div_pulse) cnt++;
    end
    check_int("R2", cnt, 0);

    // R7 and R4: bypassed, ratio 7
    tag = "R7";
    restart(9'd7, 1'b1);
    gap_to_pulse(g);
    check_int("R7", g, 7);
    tag = "R4";
    gap_to_pulse(g);
    check_int("R4", g, 7);
    @(negedge clk);
    check_int("R6", int'(div_pulse), 0);

    // R3: prescaled, ratio 5
    tag = "R3";
    restart(9'd5, 1'b0);
    gap_to_pulse(g);
    check_int("R3", g, 20);
    gap_to_pulse(g);
    check_int("R3", g, 20);

    // R5: small ratios clamp
    tag = "R5";
    restart(9'd2, 1'b1);
    gap_to_pulse(g);
    check_int("R5", g, 4);
    restart(9'd0, 1'b0);
    gap_to_pulse(g);
    check_int("R5", g, 16);

    // R11: maximum ratio
    tag = "R11";
    restart(9'd511, 1'b1);
    gap_to_pulse(g);
    check_int("R11", g, 511);
    restart(9'd511, 1'b0);
    gap_to_pulse(g);
    check_int("R11", g, 2044);

    // R10: sparse strobes, every third cycle
    tag = "R10";
    restart(9'd6, 1'b1);
    in_tick = 1'b0;
    cnt = 0;
    g = 0;
    for (int i = 0; i < 200; i++) begin
      in_tick = (i % 3 == 0);
      @(negedge clk);
      if (div_pulse) begin
        if (cnt > 0) check_int("R10", i - g, 18);
        g = i;
        cnt++;
      end
    end
    check_int("R10", (cnt > 2) ? 1 : 0, 1);
    in_tick = 1'b1;

    // R8: ratio change mid-period
    tag = "R8";
    restart(9'd10, 1'b1);
    gap_to_pulse(g);
    repeat (3) @(negedge clk);
    ratio = 9'd5;
    gap_to_pulse(g);
    check_int("R8", g, 7);
    gap_to_pulse(g);
    check_int("R8", g, 5);

    // R9: mode change mid-period
    tag = "R9";
    restart(9'd4, 1'b1);
    gap_to_pulse(g);
    @(negedge clk);
    bypass_pre = 1'b0;
    gap_to_pulse(g);
    check_int("R9", g, 3);
    gap_to_pulse(g);
    check_int("R9", g, 16);

    // R2: disable while running
    tag = "R2";
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    cnt = 0;
    repeat (40) begin
      @(negedge clk);
      if (div_pulse) cnt++;
    end
    check_int("R2", cnt, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule